// File: doc/BRIEF.md
# Dual-Channel Shared-Timebase Pulse-Width Modulator

This block produces two pulse-width-modulated output levels from a single timebase. An internal divide-by-two enable feeds an 8-bit programmable prescaler. The prescaler in turn steps an 8-bit counter that runs modulo 255. Each channel holds its own 8-bit duty value and compares it with the shared count. The channel output is driven low while the duty value is above the count and high otherwise. The duty value sets the low fraction of each period in steps of 1/255.

A plain register write port loads three values: the two duty values and the prescaler. The block accepts a write in the single cycle where `wr_en` is high. There is no back-pressure and no read path. Written values are first held in staging registers. They move into the working registers only when the counter wraps back to 0. As a result, a period is never cut short or stretched by a write in mid-period.

Top module: `pwm_dual_top`

## Requirements
- R1: The shared counter starts at 0 after reset and counts 0, 1, …, 254. After 254 it returns to 0, so it never holds the value 255.
- R2: The counter advances once every 2 × (P+1) clocks, where P is the working prescaler value. One output period is therefore 510 × (P+1) clocks.
- R3: A channel output is low in every clock where its working duty value D is greater than the count, and high otherwise. Over one period the output is low for D × 2 × (P+1) clocks and high for (255 − D) × 2 × (P+1) clocks.
- R4: A duty value of 00h keeps the output high for the whole period. A duty value of FFh keeps it low for the whole period.
- R5: Both channels share one counter and one prescaler. Their low phases both begin at the counter wrap. Over a period the two outputs therefore differ for exactly |D0 − D1| × 2 × (P+1) clocks.
- R6: A write with `wr_en` high decodes `wr_addr` as follows: 0 loads the duty value of channel 0, 1 loads the duty value of channel 1, 2 loads the prescaler, and 3 is ignored.
- R7: A written duty or prescaler value takes effect at the next wrap of the counter from 254 to 0. Before that wrap, the outputs keep following the old values.
- R8: Reset clears the prescaler, the counter and both duty values, so both outputs are high after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per high cycle |
| wr_addr | input | 2 | Register select (0 duty ch0, 1 duty ch1, 2 prescaler, 3 none) |
| wr_data | input | 8 | Write value |
| pwm_o | output | 2 | Output levels, bit n is channel n |

## Verification
The bench sweeps duty values, including 00h, 01h, 80h, FEh and FFh, at prescaler settings 0 and 3. For each setting it counts the high clocks and the clocks where the two channels differ over one full period, and compares them with the arithmetic expectation. These counts expose the following errors:
- A counter that wraps at 255 instead of 254 gives a period one step too long and lets FFh produce a high step.
- A comparator that uses ≥ instead of > shifts the high time by one step.
- A prescaler that lacks the divide-by-two gives half the expected period.
- A duty value that takes effect immediately shows up in a check made right after a mid-period write, before the next wrap.
- A decoder that honours address 3 changes an output that should have stayed put.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned PWM_W  = 8;
  localparam int unsigned PWM_CH = 2;
  localparam int unsigned ADDR_W = 2;
  typedef logic [PWM_W-1:0] pwm_val_t;
  localparam logic [ADDR_W-1:0] A_DUTY0 = 2'd0;
  localparam logic [ADDR_W-1:0] A_DUTY1 = 2'd1;
  localparam logic [ADDR_W-1:0] A_PRESC = 2'd2;
endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wrap,
  input  logic [W-1:0] presc_new,
  output logic         step
);
  logic         half_q;
  logic [W-1:0] pre_cnt;
  logic [W-1:0] presc_act;

  assign step = half_q && (pre_cnt == presc_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q    <= 1'b0;
      pre_cnt   <= '0;
      presc_act <= '0;
    end else begin
      half_q <= ~half_q;
      if (half_q) begin
        if (pre_cnt == presc_act) pre_cnt <= '0;
        else                      pre_cnt <= pre_cnt + 1'b1;
      end
      if (wrap) presc_act <= presc_new;
    end
  end

  // R7: working prescaler only changes on a wrap
  p_presc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(presc_act));
  // R2: prescaler count never passes the working limit
  p_pre_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pre_cnt <= presc_act);
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  localparam logic [W-1:0] CNT_MAX = W'((1 << W) - 2);

  assign wrap = step && (cnt == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (wrap) cnt <= '0;
    else if (step) cnt <= cnt + 1'b1;
  end

  // R1: count returns to zero after the top value
  p_wrap_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt == CNT_MAX) |=> (cnt == '0));
  // R2: count moves only on a prescaler step
  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(cnt));
  // R2: the divide-by-two stage spaces steps apart
  p_step_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> !step);
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wrap,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] duty_new,
  output logic         pwm_o
);
  logic [W-1:0] duty_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    duty_act <= '0;
    else if (wrap) duty_act <= duty_new;
  end

  assign pwm_o = !(duty_act > cnt);

  // R7: working duty changes only on a wrap
  p_duty_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(duty_act));
  // R4: zero duty keeps the level high
  p_zero_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_act == '0) |-> pwm_o);
  // R4: full-scale duty keeps the level low
  p_full_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_act == '1) |-> !pwm_o);
endmodule

// File: rtl/pwm_dual_top.sv
module pwm_dual_top
  import pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [PWM_W-1:0]  wr_data,
  output logic [PWM_CH-1:0] pwm_o
);
  pwm_val_t duty_sh [PWM_CH];
  pwm_val_t presc_sh;
  pwm_val_t cnt;
  logic     step;
  logic     wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_sh <= '0;
    end else if (wr_en && wr_addr == A_PRESC) begin
      presc_sh <= wr_data;
    end
  end

  pwm_tick_gen #(.W(PWM_W)) tick_i (
    .clk(clk), .rst_n(rst_n), .wrap(wrap), .presc_new(presc_sh), .step(step)
  );

  pwm_counter #(.W(PWM_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .step(step), .cnt(cnt), .wrap(wrap)
  );

  for (genvar g = 0; g < PWM_CH; g++) begin : g_ch
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            duty_sh[g] <= '0;
      else if (wr_en && wr_addr == MY_ADDR)  duty_sh[g] <= wr_data;
    end
    pwm_channel #(.W(PWM_W)) ch_i (
      .clk(clk), .rst_n(rst_n), .wrap(wrap), .cnt(cnt),
      .duty_new(duty_sh[g]), .pwm_o(pwm_o[g])
    );
  end

  // R6: the unused address leaves every staging register alone
  p_ignore_addr3_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd3) |=>
      ($stable(presc_sh) && $stable(duty_sh[0]) && $stable(duty_sh[1])));
endmodule

// File: tb/pwm_dual_top_tb_top.sv
module pwm_dual_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] pwm_o;
  int errors = 0;
  int checks = 0;
  int cur_p = 0;

  always #2.5 clk = ~clk;

  pwm_dual_top dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_o(pwm_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic measure(input int n, output int hi0, output int hi1,
                         output int dif);
    hi0 = 0; hi1 = 0; dif = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hi0 += int'(pwm_o[0]);
      hi1 += int'(pwm_o[1]);
      dif += int'(pwm_o[0] != pwm_o[1]);
    end
  endtask

  task automatic run_case(input int p, input int d0, input int d1);
    int h0, h1, df, per, st;
    int old_per;
    old_per = 510 * (cur_p + 1);
    wr(2'd2, 8'(p));
    wr(2'd0, 8'(d0));
    wr(2'd1, 8'(d1));
    cur_p = p;
    per = 510 * (p + 1);
    st  = 2 * (p + 1);
    repeat (old_per + per + 4) @(negedge clk);
    measure(per, h0, h1, df);
    // R2 R3 high time per period; R4 when duty is 00h or FFh
    check((d0 == 0 || d0 == 255) ? "R4 ch0" : "R3 ch0", h0, (255 - d0) * st);
    check((d1 == 0 || d1 == 255) ? "R4 ch1" : "R2 ch1", h1, (255 - d1) * st);
    // R5 shared timebase: outputs differ by duty gap
    check("R5 diff", df, ((d0 > d1) ? d0 - d1 : d1 - d0) * st);
  endtask

  initial begin
    repeat (200000 - 100) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int h0, h1, df;
    int duties[7] = '{0, 1, 128, 254, 255, 64, 127};
    repeat (3) @(negedge clk);
    // R8 reset leaves both outputs high
    check("R8 reset ch0", int'(pwm_o[0]), 1);
    check("R8 reset ch1", int'(pwm_o[1]), 1);
    @(negedge clk);
    rst_n = 1'b1;
    // R7 mid-period write must not act before the wrap
    wr(2'd0, 8'hFF);
    measure(20, h0, h1, df);
    check("R7 early ch0", h0, 20);
    // R1 R8 reset period is 510 clocks with prescaler 0; wait it out
    repeat (510) @(negedge clk);
    measure(510, h0, h1, df);
    check("R1 R7 after wrap ch0", h0, 0);
    check("R8 ch1 stays high", h1, 510);
    // R6 address 3 ignored
    wr(2'd3, 8'h80);
    repeat (1030) @(negedge clk);
    measure(510, h0, h1, df);
    check("R6 addr3 ch0", h0, 0);
    check("R6 addr3 ch1", h1, 510);
    for (int pi = 0; pi < 2; pi++) begin
      for (int k = 0; k < 7; k++) begin
        run_case(pi * 3, duties[k], duties[6 - k]);
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule